// File: doc/BRIEF.md
# Speculative Load Exception Resolver

This block decides what happens to one load instruction when several exception conditions are detected for it in the same cycle. Each condition is one bit of an input vector. The caller also says whether the load is speculative, and gives a deferral policy with one enable bit per condition. The block works in three ordered steps:

1. **Qualification** removes every condition that a concurrent, more fundamental condition makes meaningless.
2. **Deferral** applies only to speculative loads. It drops the data-memory conditions whose policy bit is set.
3. **Prioritization** reports the lowest-numbered condition that is left as the fault to raise.

Because deferral happens before prioritization, a speculative load can fault on a lower-priority condition that was not deferred, even while a higher-priority one is deferred. If every qualified condition of a speculative load is deferred, the block raises no fault. Instead it asserts a defer indication, so the pipeline can tag the destination register as deferred.

The result is registered. It appears one clock after the request and is held until the next clock edge.

Top module: `spec_load_resolver`

## Requirements
- R1: A synchronous active-high reset clears fault_valid and defer_out, and fault_idx reads 0.
- R2: Outputs reflect the request sampled at the previous rising edge. A cycle with req_valid low yields fault_valid=0 and defer_out=0, whatever the other inputs are.
- R3: Condition bit positions, with lower index meaning higher priority:
  - 0 abort
  - 1 external interrupt
  - 2 register-stack fault
  - 3 instruction-fetch fault
  - 4 illegal operation
  - 5 FP register disabled
  - 6 NaT address register
  - 7 unimplemented address
  - 8 page-walk data fault
  - 9 data TLB miss
  - 10 alternate TLB miss
  - 11 page absent
  - 12 NaT page access
  - 13 key miss
  - 14 key permission
  - 15 access rights
  - 16 access bit
  - 17 data debug
  - 18 misaligned
  - 19 unsupported reference

  When several qualified conditions survive, fault_idx is the lowest index among them.
- R4: A non-speculative load with exactly one condition raises that condition, and defer_out stays 0.
- R5: Qualification drops a condition if any of its blockers is also present:
  - bit 7 is blocked by {6}
  - bits 8, 9 and 10 are blocked by {6,7}
  - bit 11 is blocked by {6,7,8,9,10}
  - bits 12, 13, 16 and 19 are blocked by {6..11}
  - bits 14 and 15 are blocked by {6..11,13}
  - bits 17 and 18 are blocked by {6,7}
  - bits 0 to 6 are never blocked.
- R6: On a speculative load, a qualified data condition (bits 6 to 19) whose policy bit is set is dropped. The highest-priority remaining condition is raised, even if it has lower priority than a dropped one.
- R7: Bits 0 to 5 are never deferred. On a speculative load they are raised regardless of their policy bits.
- R8: On a speculative load where at least one qualified condition is deferred and none remains, defer_out=1 and fault_valid=0.
- R9: fault_valid and defer_out are never both high. A speculative load with no conditions gives neither.
- R10: The policy input has no effect on a non-speculative load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A load is presented this cycle |
| req_spec | input | 1 | The load is speculative (1) or non-speculative (0) |
| req_cond | input | 20 | Detected conditions, one bit each, in the order given in R3 |
| req_policy | input | 20 | Per-condition deferral enables; only bits 6 to 19 are honoured |
| fault_valid | output | 1 | A fault is to be raised |
| fault_idx | output | 5 | Bit index of the raised condition |
| defer_out | output | 1 | All qualified conditions were deferred; tag the target |

## Verification
Some properties are checked by the assertions on every cycle:
- the reset state;
- quiet outputs after an idle cycle;
- the exclusivity of fault and defer;
- that a raised index was really present in the previous request;
- that a non-speculative load never defers;
- that any of bits 0 to 5 always forces a fault among those bits;
- that a NaT address register with nothing above it wins unless it is deferred.

Other behaviour can only be shown by the bench's sweeps, which run every single condition and every pair of conditions under both speculation settings and several policy patterns. These include:
- the exact preclusion sets;
- the choice of a lower-priority survivor once a higher one is deferred;
- the exact index picked among several survivors.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int NCOND = 20;
  localparam int IDX_W = $clog2(NCOND);

  // condition positions (lower index = higher priority)
  localparam int C_ABORT     = 0;
  localparam int C_EXTINT    = 1;
  localparam int C_RSE       = 2;
  localparam int C_IFETCH    = 3;
  localparam int C_ILLOP     = 4;
  localparam int C_FPDIS     = 5;
  localparam int C_NATREG    = 6;
  localparam int C_UNIMPL    = 7;
  localparam int C_WALK      = 8;
  localparam int C_TLB       = 9;
  localparam int C_ALTTLB    = 10;
  localparam int C_ABSENT    = 11;
  localparam int C_NATPAGE   = 12;
  localparam int C_KEYMISS   = 13;
  localparam int C_KEYPERM   = 14;
  localparam int C_RIGHTS    = 15;
  localparam int C_ABIT      = 16;
  localparam int C_DEBUG     = 17;
  localparam int C_MISALIGN  = 18;
  localparam int C_UNSUPP    = 19;

  localparam int FIRST_DATA  = C_NATREG;

  function automatic logic [NCOND-1:0] bit_of(input int i);
    return NCOND'(1) << i;
  endfunction

  // conditions that may be deferred by policy
  function automatic logic [NCOND-1:0] data_mask();
    logic [NCOND-1:0] m;
    m = '0;
    for (int i = FIRST_DATA; i < NCOND; i++) m[i] = 1'b1;
    return m;
  endfunction

  // set of concurrent conditions that make condition idx meaningless
  function automatic logic [NCOND-1:0] blockers(input int idx);
    logic [NCOND-1:0] base, xlat, page;
    base = bit_of(C_NATREG) | bit_of(C_UNIMPL);
    xlat = base | bit_of(C_WALK) | bit_of(C_TLB) | bit_of(C_ALTTLB);
    page = xlat | bit_of(C_ABSENT);
    case (idx)
      C_UNIMPL:                          return bit_of(C_NATREG);
      C_WALK, C_TLB, C_ALTTLB:           return base;
      C_ABSENT:                          return xlat;
      C_NATPAGE, C_KEYMISS, C_ABIT,
      C_UNSUPP:                          return page;
      C_KEYPERM, C_RIGHTS:               return page | bit_of(C_KEYMISS);
      C_DEBUG, C_MISALIGN:               return base;
      default:                           return '0;
    endcase
  endfunction
endpackage

// File: rtl/slr_qualify.sv
module slr_qualify
  import slr_pkg::*;
#(
  parameter int N = NCOND
) (
  input  logic [N-1:0] cond,
  output logic [N-1:0] qual
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [N-1:0] blk;
    assign blk     = N'(blockers(g));
    assign qual[g] = cond[g] & ~|(cond & blk);
  end
endmodule

// File: rtl/slr_defer.sv
module slr_defer
  import slr_pkg::*;
#(
  parameter int N = NCOND
) (
  input  logic         spec,
  input  logic [N-1:0] qual,
  input  logic [N-1:0] policy,
  output logic [N-1:0] keep,
  output logic         all_dropped
);
  logic [N-1:0] eligible;
  logic [N-1:0] dropped;

  assign eligible    = policy & N'(data_mask());
  assign dropped     = spec ? (qual & eligible) : '0;
  assign keep        = qual & ~dropped;
  assign all_dropped = (|dropped) & ~(|keep);
endmodule

// File: rtl/slr_pick.sv
module slr_pick
  import slr_pkg::*;
#(
  parameter int N  = NCOND,
  parameter int IW = IDX_W
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign first[g]  = vec[g] & ~seen[g];
    assign seen[g+1] = seen[g] | vec[g];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (first[i]) idx = idx | IW'(i);
  end
endmodule

// File: rtl/spec_load_resolver.sv
module spec_load_resolver
  import slr_pkg::*;
#(
  parameter int N  = NCOND,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_spec,
  input  logic [N-1:0]  req_cond,
  input  logic [N-1:0]  req_policy,
  output logic          fault_valid,
  output logic [IW-1:0] fault_idx,
  output logic          defer_out
);
  logic [N-1:0]  qual_w;
  logic [N-1:0]  keep_w;
  logic          all_dropped_w;
  logic          raise_w;
  logic [IW-1:0] raise_idx_w;
  logic          hist_ok;

  slr_qualify #(.N(N)) u_qual (
    .cond (req_cond),
    .qual (qual_w)
  );

  slr_defer #(.N(N)) u_defer (
    .spec        (req_spec),
    .qual        (qual_w),
    .policy      (req_policy),
    .keep        (keep_w),
    .all_dropped (all_dropped_w)
  );

  slr_pick #(.N(N), .IW(IW)) u_pick (
    .vec (keep_w),
    .any (raise_w),
    .idx (raise_idx_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_valid <= 1'b0;
      fault_idx   <= '0;
      defer_out   <= 1'b0;
      hist_ok     <= 1'b0;
    end else begin
      fault_valid <= req_valid & raise_w;
      fault_idx   <= req_valid ? raise_idx_w : '0;
      defer_out   <= req_valid & all_dropped_w;
      hist_ok     <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!fault_valid && !defer_out && fault_idx == '0));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && !$past(req_valid)) |-> (!fault_valid && !defer_out));

  p_fault_present_r3: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && fault_valid) |-> (($past(req_cond) >> fault_idx) & N'(1)) != '0);

  p_nonspec_no_defer_r4: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(req_valid && !req_spec)) |-> !defer_out);

  p_natreg_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(req_valid && req_cond[C_NATREG] &&
                      (req_cond[FIRST_DATA-1:0] == '0) &&
                      !(req_spec && req_policy[C_NATREG])))
    |-> (fault_valid && fault_idx == IW'(C_NATREG)));

  p_nondata_raised_r7: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(req_valid && (req_cond[FIRST_DATA-1:0] != '0)))
    |-> (fault_valid && fault_idx < IW'(FIRST_DATA)));

  p_defer_only_spec_r8: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && defer_out) |-> $past(req_spec && req_valid));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(fault_valid && defer_out));
endmodule

// File: tb/spec_load_resolver_test.sv
module spec_load_resolver_test;
  localparam int N = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_spec = 1'b0;
  logic [N-1:0]  req_cond = '0;
  logic [N-1:0]  req_policy = '0;
  logic          fault_valid;
  logic [4:0]    fault_idx;
  logic          defer_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spec_load_resolver uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_spec(req_spec),
    .req_cond(req_cond), .req_policy(req_policy),
    .fault_valid(fault_valid), .fault_idx(fault_idx), .defer_out(defer_out)
  );

  // blocker sets restated from R5
  function automatic logic [N-1:0] rng(input int lo, input int hi);
    logic [N-1:0] m = '0;
    for (int k = lo; k <= hi; k++) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [N-1:0] blk_of(input int i);
    if (i == 7) return rng(6, 6);
    if (i >= 8 && i <= 10) return rng(6, 7);
    if (i == 11) return rng(6, 10);
    if (i == 12 || i == 13 || i == 16 || i == 19) return rng(6, 11);
    if (i == 14 || i == 15) return rng(6, 11) | rng(13, 13);
    if (i == 17 || i == 18) return rng(6, 7);
    return '0;
  endfunction

  function automatic logic [N-1:0] ref_qual(input logic [N-1:0] c);
    logic [N-1:0] q = '0;
    for (int i = 0; i < N; i++) q[i] = c[i] && ((c & blk_of(i)) == '0);
    return q;
  endfunction

  // {valid, idx[4:0], defer}
  function automatic logic [6:0] ref_out(input logic v, input logic s,
                                         input logic [N-1:0] c, input logic [N-1:0] p);
    logic [N-1:0] q, d, r;
    logic fv = 1'b0;
    logic [4:0] fi = '0;
    if (!v) return '0;
    q = ref_qual(c);
    d = s ? (q & p & rng(6, N-1)) : '0;
    r = q & ~d;
    for (int i = N-1; i >= 0; i--)
      if (r[i]) begin fv = 1'b1; fi = 5'(i); end
    return {fv, fi, (s && d != '0 && r == '0)};
  endfunction

  function automatic string tag_of(input logic v, input logic s,
                                   input logic [N-1:0] c, input logic [N-1:0] p);
    logic [6:0] e = ref_out(v, s, c, p);
    if (!v) return "R2";
    if (e[0]) return "R8";
    if (s && c[5:0] != '0) return "R7";
    if (s) return "R6";
    if (ref_qual(c) != c) return "R5";
    if (p != '0) return "R10";
    if ($countones(c) >= 2) return "R3";
    return "R4";
  endfunction

  task automatic apply(input logic v, input logic s,
                       input logic [N-1:0] c, input logic [N-1:0] p);
    logic [6:0] exp;
    string t;
    @(negedge clk);
    req_valid = v; req_spec = s; req_cond = c; req_policy = p;
    @(negedge clk);
    exp = ref_out(v, s, c, p);
    t = tag_of(v, s, c, p);
    n_vec++;
    if ({fault_valid, fault_idx, defer_out} !== exp) begin
      n_bad++;
      $display("FAIL %s cond=%h spec=%b pol=%h: got v=%b idx=%0d def=%b, exp v=%b idx=%0d def=%b",
               t, c, s, p, fault_valid, fault_idx, defer_out, exp[6], exp[5:1], exp[0]);
    end
    n_vec++;
    if (fault_valid && defer_out) begin
      n_bad++;
      $display("FAIL R9 both outputs high: got 1/1 exp not both");
    end
  endtask

  initial begin
    logic [N-1:0] pols [4];
    pols[0] = '0; pols[1] = '1; pols[2] = 20'hAAAAA; pols[3] = 20'h55555;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (fault_valid !== 1'b0 || defer_out !== 1'b0 || fault_idx !== 5'd0) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%b idx=%0d def=%b exp 0/0/0", fault_valid, fault_idx, defer_out);
    end
    rst = 1'b0;
    // R2: idle cycles ignore other inputs
    apply(1'b0, 1'b1, 20'hFFFFF, 20'h00000);
    apply(1'b0, 1'b0, 20'h00400, 20'hFFFFF);
    // R9: speculative load with nothing detected
    apply(1'b1, 1'b1, '0, '1);
    // R2: latency — output still old just before the edge
    @(negedge clk);
    req_valid = 1'b1; req_spec = 1'b0; req_cond = 20'h00200; req_policy = '0;
    @(posedge clk); #1;
    n_vec++;
    if (fault_valid !== 1'b1 || fault_idx !== 5'd9) begin
      n_bad++;
      $display("FAIL R2 latency: got v=%b idx=%0d exp v=1 idx=9", fault_valid, fault_idx);
    end
    // sweep: all singles and pairs
    for (int sp = 0; sp < 2; sp++)
      for (int pi = 0; pi < 4; pi++)
        for (int a = 0; a < N; a++)
          for (int b = a; b < N; b++)
            apply(1'b1, sp[0], (20'(1) << a) | (20'(1) << b), pols[pi]);
    // R6: deferred TLB miss exposes the misaligned fault
    apply(1'b1, 1'b1, 20'h40200, 20'h00200);
    // R8: whole translation chain deferred
    apply(1'b1, 1'b1, 20'h0FE00, 20'hFFFC0);
    // R7: policy bits on non-data conditions ignored
    apply(1'b1, 1'b1, 20'h00010 | 20'h00040, 20'hFFFFF);
    // R5: triple with key miss gating permission
    apply(1'b1, 1'b0, 20'h0E000, '0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule